// File: doc/BRIEF.md
# Stress-Sweep Switching-Rate Monitor Controller

This block sequences an on-die variation monitor built from a column of resistive memory cells. It sweeps upward through a set of stress levels. At each level it asks the analog side to stress the whole column at once. It then reads each cell in ascending address order. A cell whose sensed value no longer matches the expected high-resistance value counts as flipped. Each flipped cell gets a restoring write right after its read, so the column is back in its initial state before the next stress. Cells that did not flip get no action.

When the scan of a level ends, the number of flipped cells is compared with a threshold captured at start. If the count meets the threshold, that level is reported. Otherwise the count clears and the next higher level is tried. If even the top level falls short, the top level is reported with a saturation flag. The stress pulse, the read and the restore are requests to the analog side. Each is held for a minimum number of clock cycles, set by a parameter, and until the matching acknowledge is high.

Top module: `msw_sweep_ctrl`

## Requirements
- R1: After reset, busy, done, level_out and saturated are 0 and no stress, read or restore request is active.
- R2: While idle, start begins a sweep at stress level 0 and captures threshold. While busy, start and threshold changes have no effect on the sweep or its result.
- R3: Each request (stress, read, restore) stays high for at least its parameter number of cycles and until its acknowledge is high. stress_lvl and cell_addr stay stable while the request waits.
- R4: After each stress operation, the cells are read one per read request at addresses 0, 1, ... N_CELLS-1, in ascending order.
- R5: A read that returns read_bit = 0 (differing from the expected value 1) counts as one flipped cell. A read that returns 1 does not count.
- R6: A flipped cell receives exactly one restore request, issued in the cycle after its read completes, at the same address. An unflipped cell receives none. All cells therefore hold 1 when the next stress begins.
- R7: After the last cell of a level, if the flip count is at least the threshold, done pulses, level_out takes that level, saturated is 0 and busy falls.
- R8: If the count is below the threshold and the level is not the top, the count clears and a new stress operation begins at the next higher level.
- R9: If the top level (N_LEVELS-1) completes below the threshold, done pulses with level_out = N_LEVELS-1 and saturated = 1.
- R10: done is high for exactly one cycle. level_out and saturated hold their values until the next sweep completes.
- R11: A threshold of 0 is met at level 0. A threshold of N_CELLS is met only at a level where every cell flips.
- R12: At most one of stress_req, read_req and restore_req is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep when idle |
| threshold | input | CNT_W | Flip count needed to report a level |
| stress_req | output | 1 | Stress pulse request to the analog side |
| stress_lvl | output | LVL_W | Stress level being applied |
| stress_ack | input | 1 | Stress operation acknowledge |
| cell_addr | output | ADDR_W | Address of the cell being read or restored |
| read_req | output | 1 | Read request for cell_addr |
| read_ack | input | 1 | Read acknowledge; read_bit valid |
| read_bit | input | 1 | Sensed cell value, 1 = unflipped |
| restore_req | output | 1 | Restoring write request for cell_addr |
| restore_ack | input | 1 | Restore acknowledge |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| level_out | output | LVL_W | Reported stress level |
| saturated | output | 1 | Top level reached without meeting threshold |

## Verification
The sweep is driven by a cell model whose flip count per level grows linearly with the level. Different bases, slopes and thresholds place the first passing level at 0, in the middle, at the top, and beyond the top. A flat profile one below the threshold separates "met" from "saturated". A threshold of 0 and a threshold equal to the column size probe the two ends of the comparison. The read addresses, the number of stress operations and the number of restore requests are checked against the profile, which tells a missed or extra restore apart from a wrong result level. Directed runs stall stress_ack and pulse start mid-sweep with a different threshold.

// File: rtl/msw_pkg.sv
package msw_pkg;

    localparam int DEF_N_CELLS  = 256;
    localparam int DEF_N_LEVELS = 10;

    // value every cell holds before a stress operation
    localparam logic EXPECT_BIT = 1'b1;

    // analog phase indices
    localparam int PH_STRESS  = 0;
    localparam int PH_READ    = 1;
    localparam int PH_RESTORE = 2;
    localparam int NUM_PH     = 3;

    typedef enum logic [2:0] {
        SW_IDLE,
        SW_STRESS,
        SW_READ,
        SW_RESTORE,
        SW_STEP,
        SW_EVAL
    } msw_state_e;

    function automatic logic is_flipped(input logic sensed);
        return sensed != EXPECT_BIT;
    endfunction

endpackage

// File: rtl/msw_phase_timer.sv
module msw_phase_timer #(
    parameter int MIN_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ack,
    output logic fin
);
    localparam int CW = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          elapsed;

    assign elapsed = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            cnt_q <= '0;
        end else if (!elapsed) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fin = req && ack && elapsed;

endmodule

// File: rtl/msw_cell_scan.sv
module msw_cell_scan #(
    parameter int N_CELLS = msw_pkg::DEF_N_CELLS,
    localparam int ADDR_W = $clog2(N_CELLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(N_CELLS - 1);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr_q <= '0;
        end else if (step && addr_q != TOP) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (addr_q == TOP);

endmodule

// File: rtl/msw_flip_count.sv
module msw_flip_count #(
    parameter int N_CELLS = msw_pkg::DEF_N_CELLS,
    localparam int CNT_W = $clog2(N_CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             capture,
    input  logic             sensed,
    output logic             flipped,
    output logic [CNT_W-1:0] count
);
    import msw_pkg::*;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(N_CELLS);

    logic [CNT_W-1:0] cnt_q;

    assign flipped = is_flipped(sensed);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (capture && flipped && cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/msw_sweep_ctrl.sv
module msw_sweep_ctrl #(
    parameter int N_CELLS     = msw_pkg::DEF_N_CELLS,
    parameter int N_LEVELS    = msw_pkg::DEF_N_LEVELS,
    parameter int STRESS_CYC  = 20,
    parameter int READ_CYC    = 2,
    parameter int RESTORE_CYC = 2,
    localparam int ADDR_W = $clog2(N_CELLS),
    localparam int CNT_W  = $clog2(N_CELLS + 1),
    localparam int LVL_W  = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  threshold,
    output logic              stress_req,
    output logic [LVL_W-1:0]  stress_lvl,
    input  logic              stress_ack,
    output logic [ADDR_W-1:0] cell_addr,
    output logic              read_req,
    input  logic              read_ack,
    input  logic              read_bit,
    output logic              restore_req,
    input  logic              restore_ack,
    output logic              busy,
    output logic              done,
    output logic [LVL_W-1:0]  level_out,
    output logic              saturated
);
    import msw_pkg::*;

    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(N_LEVELS - 1);

    msw_state_e        state_q;
    logic [LVL_W-1:0]  level_q;
    logic [CNT_W-1:0]  thr_q;
    logic [LVL_W-1:0]  lvl_out_q;
    logic              sat_q;
    logic              done_q;

    logic [NUM_PH-1:0] ph_req;
    logic [NUM_PH-1:0] ph_ack;
    logic [NUM_PH-1:0] ph_fin;

    logic              scan_last;
    logic              cell_flipped;
    logic [CNT_W-1:0]  flip_cnt;
    logic              met;

    assign ph_req[PH_STRESS]  = (state_q == SW_STRESS);
    assign ph_req[PH_READ]    = (state_q == SW_READ);
    assign ph_req[PH_RESTORE] = (state_q == SW_RESTORE);
    assign ph_ack[PH_STRESS]  = stress_ack;
    assign ph_ack[PH_READ]    = read_ack;
    assign ph_ack[PH_RESTORE] = restore_ack;

    for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
        localparam int MC = (g == PH_STRESS) ? STRESS_CYC :
                            (g == PH_READ)   ? READ_CYC   : RESTORE_CYC;
        msw_phase_timer #(.MIN_CYC(MC)) u_tmr (
            .clk (clk),
            .rst (rst),
            .req (ph_req[g]),
            .ack (ph_ack[g]),
            .fin (ph_fin[g])
        );
    end

    // address and count restart at every stress operation
    msw_cell_scan #(.N_CELLS(N_CELLS)) u_scan (
        .clk  (clk),
        .rst  (rst),
        .clr  (ph_req[PH_STRESS]),
        .step (state_q == SW_STEP),
        .addr (cell_addr),
        .last (scan_last)
    );

    msw_flip_count #(.N_CELLS(N_CELLS)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (ph_req[PH_STRESS]),
        .capture (ph_fin[PH_READ]),
        .sensed  (read_bit),
        .flipped (cell_flipped),
        .count   (flip_cnt)
    );

    assign met = (flip_cnt >= thr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SW_IDLE;
            level_q   <= '0;
            thr_q     <= '0;
            lvl_out_q <= '0;
            sat_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SW_IDLE: begin
                    if (start) begin
                        thr_q   <= threshold;
                        level_q <= '0;
                        state_q <= SW_STRESS;
                    end
                end
                SW_STRESS: begin
                    if (ph_fin[PH_STRESS]) state_q <= SW_READ;
                end
                SW_READ: begin
                    if (ph_fin[PH_READ]) begin
                        state_q <= cell_flipped ? SW_RESTORE : SW_STEP;
                    end
                end
                SW_RESTORE: begin
                    if (ph_fin[PH_RESTORE]) state_q <= SW_STEP;
                end
                SW_STEP: begin
                    state_q <= scan_last ? SW_EVAL : SW_READ;
                end
                SW_EVAL: begin
                    if (met || level_q == TOP_LVL) begin
                        done_q    <= 1'b1;
                        lvl_out_q <= level_q;
                        sat_q     <= !met;
                        state_q   <= SW_IDLE;
                    end else begin
                        level_q <= level_q + 1'b1;
                        state_q <= SW_STRESS;
                    end
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end

    assign stress_req  = ph_req[PH_STRESS];
    assign read_req    = ph_req[PH_READ];
    assign restore_req = ph_req[PH_RESTORE];
    assign stress_lvl  = level_q;
    assign busy        = (state_q != SW_IDLE);
    assign done        = done_q;
    assign level_out   = lvl_out_q;
    assign saturated   = sat_q;

endmodule

// File: rtl/msw_sweep_ctrl_chk.sv
module msw_sweep_ctrl_chk #(
    parameter int N_CELLS  = msw_pkg::DEF_N_CELLS,
    parameter int N_LEVELS = msw_pkg::DEF_N_LEVELS,
    localparam int ADDR_W = $clog2(N_CELLS),
    localparam int LVL_W  = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              stress_req,
    input logic [LVL_W-1:0]  stress_lvl,
    input logic              stress_ack,
    input logic [ADDR_W-1:0] cell_addr,
    input logic              read_req,
    input logic              read_ack,
    input logic              read_bit,
    input logic              restore_req,
    input logic              busy,
    input logic              done,
    input logic [LVL_W-1:0]  level_out,
    input logic              saturated
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(N_LEVELS - 1);

    p_single_req_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stress_req, read_req, restore_req}));

    p_stress_hold_r3: assert property (@(posedge clk) disable iff (rst)
        stress_req && !stress_ack |=> stress_req && $stable(stress_lvl));

    p_read_hold_r3: assert property (@(posedge clk) disable iff (rst)
        read_req && !read_ack |=> read_req && $stable(cell_addr));

    p_restore_follows_flip_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(restore_req) |-> $past(read_req) && $past(read_ack)
                               && !$past(read_bit) && $stable(cell_addr));

    p_sweep_from_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(stress_req) && !$past(busy) |-> stress_lvl == '0);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !stress_req && !read_req && !restore_req);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_out) || !$stable(saturated) |-> done);

    p_sat_top_r9: assert property (@(posedge clk) disable iff (rst)
        saturated |-> level_out == TOP_LVL);

endmodule

bind msw_sweep_ctrl msw_sweep_ctrl_chk #(
    .N_CELLS  (N_CELLS),
    .N_LEVELS (N_LEVELS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .stress_req  (stress_req),
    .stress_lvl  (stress_lvl),
    .stress_ack  (stress_ack),
    .cell_addr   (cell_addr),
    .read_req    (read_req),
    .read_ack    (read_ack),
    .read_bit    (read_bit),
    .restore_req (restore_req),
    .busy        (busy),
    .done        (done),
    .level_out   (level_out),
    .saturated   (saturated)
);

// File: tb/msw_sweep_ctrl_tb.sv
module msw_sweep_ctrl_tb;

    localparam int N_CELLS  = 256;
    localparam int N_LEVELS = 10;
    localparam int ADDR_W   = $clog2(N_CELLS);
    localparam int CNT_W    = $clog2(N_CELLS + 1);
    localparam int LVL_W    = $clog2(N_LEVELS);
    localparam int WD_LIMIT = 190000;

    // threshold, flip base, flip slope per level, expected level, expected saturation
    localparam int NV = 7;
    localparam int VEC [NV][5] = '{
        '{ 64,  0, 10, 7, 0},
        '{ 64, 64,  0, 0, 0},
        '{ 64, 63,  0, 9, 1},
        '{200,  0, 25, 8, 0},
        '{256,  0, 30, 9, 0},
        '{  1,  0,  1, 1, 0},
        '{  0,  0,  0, 0, 0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  threshold = '0;
    logic              stress_req;
    logic [LVL_W-1:0]  stress_lvl;
    logic              stress_ack = 1'b1;
    logic [ADDR_W-1:0] cell_addr;
    logic              read_req;
    logic              read_ack = 1'b1;
    logic              read_bit;
    logic              restore_req;
    logic              restore_ack = 1'b1;
    logic              busy;
    logic              done;
    logic [LVL_W-1:0]  level_out;
    logic              saturated;

    always #5 clk = ~clk;

    msw_sweep_ctrl #(
        .N_CELLS(N_CELLS), .N_LEVELS(N_LEVELS),
        .STRESS_CYC(3), .READ_CYC(1), .RESTORE_CYC(1)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .threshold(threshold),
        .stress_req(stress_req), .stress_lvl(stress_lvl), .stress_ack(stress_ack),
        .cell_addr(cell_addr), .read_req(read_req), .read_ack(read_ack),
        .read_bit(read_bit), .restore_req(restore_req), .restore_ack(restore_ack),
        .busy(busy), .done(done), .level_out(level_out), .saturated(saturated)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic timed_out = 1'b0;

    // cell column model: flip count grows linearly with level
    int prof_base = 0;
    int prof_step = 0;
    logic [N_CELLS-1:0] cells;

    function automatic int nflip(input int lvl);
        int v = prof_base + prof_step * lvl;
        return (v > N_CELLS) ? N_CELLS : v;
    endfunction

    assign read_bit = cells[cell_addr];

    always @(posedge clk) begin
        if (rst) begin
            cells <= '1;
        end else begin
            if (stress_req) begin
                for (int i = 0; i < N_CELLS; i++)
                    if (i < nflip(int'(stress_lvl))) cells[i] <= 1'b0;
            end
            if (restore_req && restore_ack) cells[cell_addr] <= 1'b1;
        end
    end

    // monitor of request sequences
    logic clr_mon = 1'b0;
    logic prev_st = 1'b0, prev_rd = 1'b0, prev_rs = 1'b0;
    int st_cnt = 0, rd_idx = 0, rd_total = 0, rs_cnt = 0, scan_err = 0, multi_req = 0;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT) timed_out <= 1'b1;
        if (clr_mon) begin
            st_cnt <= 0; rd_idx <= 0; rd_total <= 0; rs_cnt <= 0; scan_err <= 0;
        end else begin
            if (stress_req && !prev_st) begin
                if (cells != '1) scan_err <= scan_err + 1;
                if (int'(stress_lvl) != st_cnt) scan_err <= scan_err + 1;
                st_cnt <= st_cnt + 1;
                rd_idx <= 0;
            end
            if (read_req && !prev_rd) begin
                if (int'(cell_addr) != rd_idx) scan_err <= scan_err + 1;
                rd_idx <= rd_idx + 1;
                rd_total <= rd_total + 1;
            end
            if (restore_req && !prev_rs) rs_cnt <= rs_cnt + 1;
        end
        if (int'(stress_req) + int'(read_req) + int'(restore_req) > 1)
            multi_req <= multi_req + 1;
        prev_st <= stress_req;
        prev_rd <= read_req;
        prev_rs <= restore_req;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic begin_run(input int thr, input int base, input int step);
        @(negedge clk);
        prof_base = base;
        prof_step = step;
        threshold = CNT_W'(thr);
        clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done && !timed_out) @(negedge clk);
    endtask

    task automatic check_result(input int exp_lvl, input int exp_sat);
        int exp_rs = 0;
        for (int l = 0; l <= exp_lvl; l++) exp_rs += nflip(l);
        check(int'(level_out) == exp_lvl, "R5 R7 R8 level", int'(level_out), exp_lvl);
        check(int'(saturated) == exp_sat, "R9 saturation", int'(saturated), exp_sat);
        check(scan_err == 0 && rd_total == N_CELLS * (exp_lvl + 1),
              "R4 scan order", rd_total, N_CELLS * (exp_lvl + 1));
        check(st_cnt == exp_lvl + 1, "R8 stress count", st_cnt, exp_lvl + 1);
        check(rs_cnt == exp_rs, "R6 restore count", rs_cnt, exp_rs);
        check(cells == '1 && !busy, "R6 R7 column restored", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({busy, done, level_out, saturated, stress_req, read_req, restore_req} == '0,
              "R1 reset", int'({busy, done, saturated, stress_req, read_req, restore_req}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !stress_req, "R1 idle after reset", int'(busy), 0);

        // vector table; R11 boundaries are the rows with threshold 0 and 256
        for (int v = 0; v < NV; v++) begin
            begin_run(VEC[v][0], VEC[v][1], VEC[v][2]);
            wait_done();
            check_result(VEC[v][3], VEC[v][4]);
            @(negedge clk);
            check(!done, "R10 done single cycle", int'(done), 0);
        end

        // R2: start and threshold change while busy are ignored
        begin_run(64, 0, 10);
        repeat (40) @(negedge clk);
        threshold = CNT_W'(1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_result(7, 0);
        check(int'(level_out) == 7, "R2 start ignored while busy", int'(level_out), 7);

        // R10: result held after done
        repeat (6) @(negedge clk);
        check(int'(level_out) == 7 && !saturated && !done && !busy,
              "R10 result held", int'(level_out), 7);

        // R3: stalled stress acknowledge keeps the request up
        stress_ack = 1'b0;
        begin_run(0, 0, 0);
        repeat (12) @(negedge clk);
        check(stress_req && !read_req && stress_lvl == '0,
              "R3 stress waits for ack", int'(stress_req), 1);
        stress_ack = 1'b1;
        wait_done();
        check(int'(level_out) == 0 && !saturated, "R3 R11 result after stall",
              int'(level_out), 0);

        check(multi_req == 0, "R12 single request", multi_req, 0);

        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule